// File: doc/BRIEF.md
# DAC command and register controller

This block is the digital control core of a dual-channel 16-bit voltage DAC. A serial front end delivers each write as one complete 24-bit word: a command byte and then two data bytes. The block decodes the word and keeps the state for every channel: an input (staging) register, a DAC (output) register and a power-down mode. It also keeps a global LDAC mask and a reference enable. It drives the output codes, the power-down modes and the reference enable to the analog side.

Two asynchronous controls arrive on their own pins. Both pass through a two-flop synchroniser and an edge detector. A falling edge on the load pin copies staged values to the outputs. A falling edge on the clear pin zeroes every input and DAC register and aborts any frame being received. While the clear pin stays low, load events are ignored. If the front end reports high-speed mode when a clear fires, the block sends it a one-cycle request to leave that mode.

A frame state machine governs reception. It has four states:
- `ST_POR`: a hold window after reset, in which frames, clear and load are all ignored.
- `ST_IDLE`: waiting for a frame.
- `ST_RX`: a frame has started.
- `ST_ABORT`: a clear hit a frame that was in progress.

It has these transitions:
- `ST_POR` moves to `ST_IDLE` when the window count ends.
- `ST_IDLE` moves to `ST_RX` on a frame start.
- `ST_RX` returns to `ST_IDLE` when the frame completes, and the frame is applied.
- `ST_RX` moves to `ST_ABORT` on a clear.
- `ST_ABORT` discards any completion and moves to `ST_RX` on the next frame start.

Top module: `dac_cmd_core`

## Requirements
- R1: After reset, all output codes, power-down modes, mask bits and the reference enable are zero. For POR_CYCLES cycles after reset, completed frames, clear edges and load edges have no effect.
- R2: The frame word is laid out as follows. Bits 21:19 hold the command and bits 18:16 hold the address. Bits 15:0 hold the data. Address 000 selects channel A (code bits 15:0) and address 001 selects channel B (code bits 31:16). Address 111 selects both channels, and any other address selects none.
- R3: Command 000 writes the data into the addressed input registers and leaves the output codes unchanged. Command 001 copies each addressed input register into its DAC register.
- R4: Command 011 writes the data into both the input register and the DAC register of each addressed channel. Command 010 writes the addressed input registers, then loads every channel's DAC register from its input register, using the newly written value where one was written.
- R5: Command 100 loads data bits 5:4 as the power-down mode of each channel whose select bit is 1. The select bits are data bit 0 for channel A and data bit 1 for channel B. The power-down mode is 2 bits per channel: A on bits 1:0, B on bits 3:2.
- R6: Command 110 loads the LDAC mask from data bits 1:0, with bit 0 for channel A. A falling edge on ldac_n copies the input register into the DAC register for each channel whose mask bit is 0.
- R7: Command 111 sets the reference enable to data bit 0.
- R8: Command 101 with data bit 0 = 0 zeroes only the DAC registers. Command 101 with data bit 0 = 1 zeroes the input registers, the DAC registers, the mask, the power-down modes and the reference enable.
- R9: A falling edge on clr_n zeroes every input register and every DAC register. The power-down modes and the reference enable are left unchanged.
- R10: While clr_n is low, falling edges on ldac_n have no effect.
- R11: A clear that arrives after a frame start and before that frame completes aborts the frame. A completion that follows before the next frame start is discarded, and the next complete frame is applied normally.
- R12: When a clear edge fires while hs_active is high, hs_exit pulses high for exactly one cycle. No pulse is made when hs_active is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Active-low power-on reset |
| frame_start | input | 1 | High when a command byte begins |
| frame_valid | input | 1 | One-cycle pulse with a complete frame word |
| frame_word | input | 24 | Command byte and 16 data bits |
| hs_active | input | 1 | Front end is in high-speed mode |
| clr_n | input | 1 | Asynchronous clear, falling-edge active |
| ldac_n | input | 1 | Asynchronous load, falling-edge active |
| dac_code | output | 32 | Output codes, channel A in bits 15:0 |
| pd_mode | output | 4 | Power-down modes, 2 bits per channel |
| ref_on | output | 1 | Internal reference enable |
| hs_exit | output | 1 | Request to leave high-speed mode |

## Verification
Most wrong internal states appear at dac_code within one cycle of the frame that exposes them. Examples are a stale input register, a mis-set mask bit, or a state machine left in the wrong state. An update command, a load edge or a fresh write would reveal the fault. A frame state left in abort would silently drop the next write. A clear or load path that misbehaves shows about three cycles after the pin edge, because of the synchroniser. A wrong power-down mode or reference enable shows on pd_mode and ref_on as soon as its command is applied, and a clear must leave both of these unchanged.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
    typedef enum logic [2:0] {
        CMD_WR_IN      = 3'b000,
        CMD_UPD        = 3'b001,
        CMD_WR_UPD_ALL = 3'b010,
        CMD_WR_UPD     = 3'b011,
        CMD_PWRDN      = 3'b100,
        CMD_RESET      = 3'b101,
        CMD_LDMASK     = 3'b110,
        CMD_REF        = 3'b111
    } dacc_cmd_e;

    typedef enum logic [1:0] {
        ST_POR, ST_IDLE, ST_RX, ST_ABORT
    } dacc_state_e;

    localparam logic [2:0] ADDR_BOTH = 3'b111;
endpackage

// File: rtl/dacc_sync_edge.sv
module dacc_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic low,
    output logic fall
);
    logic s1, s2, s3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= pin_n;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign low  = ~s2;
    assign fall = s3 & ~s2;
endmodule

// File: rtl/dacc_frame_fsm.sv
module dacc_frame_fsm
    import dacc_pkg::*;
#(
    parameter int POR_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic frame_valid,
    input  logic clr_ev,
    output logic apply,
    output logic por_busy,
    output logic in_abort
);
    localparam int CW = $clog2(POR_CYCLES + 1);

    dacc_state_e state, state_nx;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_POR;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_POR) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_POR:   if (cnt == CW'(POR_CYCLES - 1)) state_nx = ST_IDLE;
            ST_IDLE:  if (frame_start) state_nx = ST_RX;
            ST_RX: begin
                if (clr_ev)           state_nx = ST_ABORT;
                else if (frame_valid) state_nx = ST_IDLE;
            end
            ST_ABORT: if (frame_start && !clr_ev) state_nx = ST_RX;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        apply    = 1'b0;
        por_busy = 1'b0;
        in_abort = 1'b0;
        unique case (state)
            ST_POR:   por_busy = 1'b1;
            ST_IDLE:  apply = frame_valid & ~clr_ev;
            ST_RX:    apply = frame_valid & ~clr_ev;
            ST_ABORT: in_abort = 1'b1;
            default:  apply = 1'b0;
        endcase
    end
endmodule

// File: rtl/dacc_channel.sv
module dacc_channel #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] data,
    input  logic          load_in,
    input  logic          load_dac_data,
    input  logic          load_dac_in,
    input  logic          zero_dac,
    input  logic          zero_all,
    input  logic          pd_load,
    input  logic [1:0]    pd_val,
    input  logic          pd_zero,
    output logic [DW-1:0] code,
    output logic [1:0]    pd
);
    logic [DW-1:0] in_r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_r <= '0;
            code <= '0;
        end else if (zero_all) begin
            in_r <= '0;
            code <= '0;
        end else begin
            if (load_in) in_r <= data;
            if (zero_dac)           code <= '0;
            else if (load_dac_data) code <= data;
            else if (load_dac_in)   code <= in_r;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pd <= 2'b00;
        else if (pd_zero) pd <= 2'b00;
        else if (pd_load) pd <= pd_val;
    end
endmodule

// File: rtl/dac_cmd_core.sv
module dac_cmd_core
    import dacc_pkg::*;
#(
    parameter int NCH        = 2,
    parameter int DW         = 16,
    parameter int POR_CYCLES = 16,
    localparam int FW        = DW + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              frame_valid,
    input  logic [FW-1:0]     frame_word,
    input  logic              hs_active,
    input  logic              clr_n,
    input  logic              ldac_n,
    output logic [NCH*DW-1:0] dac_code,
    output logic [NCH*2-1:0]  pd_mode,
    output logic              ref_on,
    output logic              hs_exit
);
    logic clr_low, clr_fall, ldac_low, ldac_fall;
    logic apply, por_busy, in_abort;
    logic clr_ev, ldac_ev, full_rst;
    logic [NCH-1:0] mask_r;

    dacc_cmd_e     cmd;
    logic [2:0]    addr;
    logic [DW-1:0] data;

    assign cmd  = dacc_cmd_e'(frame_word[DW+5:DW+3]);
    assign addr = frame_word[DW+2:DW];
    assign data = frame_word[DW-1:0];

    dacc_sync_edge u_clr_sync (
        .clk(clk), .rst_n(rst_n), .pin_n(clr_n), .low(clr_low), .fall(clr_fall));

    dacc_sync_edge u_ldac_sync (
        .clk(clk), .rst_n(rst_n), .pin_n(ldac_n), .low(ldac_low), .fall(ldac_fall));

    assign clr_ev  = clr_fall & ~por_busy;
    assign ldac_ev = ldac_fall & ~clr_low & ~por_busy;

    dacc_frame_fsm #(.POR_CYCLES(POR_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .frame_valid(frame_valid), .clr_ev(clr_ev), .apply(apply),
        .por_busy(por_busy), .in_abort(in_abort));

    assign full_rst = apply & (cmd == CMD_RESET) & data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_r  <= '0;
            ref_on  <= 1'b0;
            hs_exit <= 1'b0;
        end else begin
            hs_exit <= clr_ev & hs_active;
            if (full_rst) begin
                mask_r <= '0;
                ref_on <= 1'b0;
            end else if (apply && cmd == CMD_LDMASK) begin
                mask_r <= data[NCH-1:0];
            end else if (apply && cmd == CMD_REF) begin
                ref_on <= data[0];
            end
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel, wr, ld_data, ld_in;
        assign sel     = (addr == 3'(i)) || (addr == ADDR_BOTH);
        assign wr      = apply & sel & (cmd == CMD_WR_IN || cmd == CMD_WR_UPD ||
                                        cmd == CMD_WR_UPD_ALL);
        assign ld_data = apply & sel & (cmd == CMD_WR_UPD || cmd == CMD_WR_UPD_ALL);
        assign ld_in   = (apply & ((sel & cmd == CMD_UPD) | (~sel & cmd == CMD_WR_UPD_ALL)))
                       | (ldac_ev & ~mask_r[i]);

        dacc_channel #(.DW(DW)) u_ch (
            .clk(clk), .rst_n(rst_n), .data(data),
            .load_in(wr), .load_dac_data(ld_data), .load_dac_in(ld_in),
            .zero_dac(apply & (cmd == CMD_RESET) & ~data[0]),
            .zero_all(clr_ev | full_rst),
            .pd_load(apply & (cmd == CMD_PWRDN) & data[i]),
            .pd_val(data[5:4]), .pd_zero(full_rst),
            .code(dac_code[i*DW +: DW]), .pd(pd_mode[i*2 +: 2]));
    end
endmodule

// File: rtl/dacc_core_chk.sv
module dacc_core_chk #(
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] dac_code,
    input logic          ref_on,
    input logic          hs_exit,
    input logic          hs_active,
    input logic          por_busy,
    input logic          clr_ev,
    input logic          clr_low,
    input logic          ldac_fall,
    input logic          ldac_ev,
    input logic          apply,
    input logic          in_abort,
    input logic          frame_valid,
    input logic          frame_start
);
    assert_por_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        por_busy |-> dac_code == '0);

    assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ev |=> dac_code == '0);

    assert_ldac_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ldac_fall && clr_low && !apply && !clr_ev) |=> $stable(dac_code));

    assert_abort_discard_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_abort && frame_valid && !frame_start && !ldac_ev && !clr_ev)
        |=> $stable(dac_code));

    assert_hs_exit_R12: assert property (@(posedge clk) disable iff (!rst_n)
        hs_exit |-> $past(hs_active));

    assert_ref_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ref_on) |-> $past(apply));
endmodule

bind dac_cmd_core dacc_core_chk #(.CW(NCH*DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .dac_code(dac_code), .ref_on(ref_on),
    .hs_exit(hs_exit), .hs_active(hs_active), .por_busy(por_busy),
    .clr_ev(clr_ev), .clr_low(clr_low), .ldac_fall(ldac_fall),
    .ldac_ev(ldac_ev), .apply(apply), .in_abort(in_abort),
    .frame_valid(frame_valid), .frame_start(frame_start));

// File: tb/tb_dac_cmd_core.sv
module tb_dac_cmd_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0, frame_valid = 1'b0;
    logic [23:0] frame_word = '0;
    logic        hs_active = 1'b0, clr_n = 1'b1, ldac_n = 1'b1;
    logic [31:0] dac_code;
    logic [3:0]  pd_mode;
    logic        ref_on, hs_exit;

    int checks = 0, errors = 0, hs_pulses = 0;

    logic [15:0] m_in [2];
    logic [15:0] m_dac [2];
    logic [1:0]  m_pd [2];
    logic [1:0]  m_mask;
    logic        m_ref;

    logic [31:0] q_code [$];
    logic [3:0]  q_pd [$];
    logic        q_ref [$];
    string       q_tag [$];

    always #4 clk = ~clk;

    dac_cmd_core dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .frame_valid(frame_valid), .frame_word(frame_word),
        .hs_active(hs_active), .clr_n(clr_n), .ldac_n(ldac_n),
        .dac_code(dac_code), .pd_mode(pd_mode), .ref_on(ref_on),
        .hs_exit(hs_exit));

    always @(posedge clk) if (hs_exit) hs_pulses++;

    task automatic model_frame(input logic [2:0] cmd, input logic [2:0] addr,
                               input logic [15:0] d);
        for (int i = 0; i < 2; i++) begin
            logic sel;
            sel = (addr == 3'(i)) || (addr == 3'b111);
            case (cmd)
                3'b000: if (sel) m_in[i] = d;
                3'b001: if (sel) m_dac[i] = m_in[i];
                3'b010: begin if (sel) m_in[i] = d; m_dac[i] = m_in[i]; end
                3'b011: if (sel) begin m_in[i] = d; m_dac[i] = d; end
                3'b100: if (d[i]) m_pd[i] = d[5:4];
                3'b101: begin
                    m_dac[i] = '0;
                    if (d[0]) begin m_in[i] = '0; m_pd[i] = '0; end
                end
                3'b110: m_mask[i] = d[i];
                default: ;
            endcase
        end
        if (cmd == 3'b111) m_ref = d[0];
        if (cmd == 3'b101 && d[0]) begin m_mask = '0; m_ref = 1'b0; end
    endtask

    task automatic push(input string tag);
        q_code.push_back({m_dac[1], m_dac[0]});
        q_pd.push_back({m_pd[1], m_pd[0]});
        q_ref.push_back(m_ref);
        q_tag.push_back(tag);
    endtask

    task automatic raw_frame(input logic [2:0] cmd, input logic [2:0] addr,
                             input logic [15:0] d);
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        repeat (2) @(negedge clk);
        frame_valid = 1'b1;
        frame_word  = {2'b00, cmd, addr, d};
        @(negedge clk) frame_valid = 1'b0;
    endtask

    task automatic send(input logic [2:0] cmd, input logic [2:0] addr,
                        input logic [15:0] d, input string tag);
        raw_frame(cmd, addr, d);
        model_frame(cmd, addr, d);
        @(negedge clk) push(tag);
    endtask

    task automatic ldac_pulse(input string tag);
        @(negedge clk) ldac_n = 1'b0;
        repeat (3) @(negedge clk);
        ldac_n = 1'b1;
        if (!(clr_n == 1'b0))
            for (int i = 0; i < 2; i++) if (!m_mask[i]) m_dac[i] = m_in[i];
        repeat (4) @(negedge clk);
        push(tag);
    endtask

    task automatic clr_fall_only;
        @(negedge clk) clr_n = 1'b0;
        repeat (5) @(negedge clk);
        for (int i = 0; i < 2; i++) begin m_in[i] = '0; m_dac[i] = '0; end
    endtask

    task automatic clr_release;
        @(negedge clk) clr_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #1;
            while (q_tag.size() > 0) begin
                logic [31:0] ec;
                logic [3:0]  ep;
                logic        er;
                string       t;
                ec = q_code.pop_front();
                ep = q_pd.pop_front();
                er = q_ref.pop_front();
                t  = q_tag.pop_front();
                checks++;
                if (dac_code !== ec || pd_mode !== ep || ref_on !== er) begin
                    errors++;
                    $display("FAIL %s: code=%h pd=%b ref=%b expected code=%h pd=%b ref=%b",
                             t, dac_code, pd_mode, ref_on, ec, ep, er);
                end
            end
        end
    end

    initial begin : watchdog
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : driver
        int base;
        for (int i = 0; i < 2; i++) begin m_in[i] = '0; m_dac[i] = '0; m_pd[i] = '0; end
        m_mask = '0;
        m_ref  = 1'b0;
        repeat (3) @(negedge clk);
        push("R1 reset state");
        rst_n = 1'b1;
        // R1: frame inside the power-on window is ignored
        raw_frame(3'b011, 3'b111, 16'h1234);
        @(negedge clk) push("R1 frame during hold window");
        repeat (20) @(negedge clk);

        send(3'b000, 3'b000, 16'h1111, "R3 write input only");
        send(3'b001, 3'b000, 16'h0000, "R3 update A from input");
        send(3'b011, 3'b001, 16'h2222, "R4 write and update B");
        send(3'b000, 3'b001, 16'h3333, "R3 stage B");
        send(3'b010, 3'b000, 16'h4444, "R4 write A update all");
        send(3'b011, 3'b010, 16'h5555, "R2 unmapped address");
        send(3'b011, 3'b111, 16'h6666, "R2 both channels");
        send(3'b100, 3'b000, 16'h0022, "R5 power-down B only");
        send(3'b100, 3'b000, 16'h0013, "R5 power-down both");
        send(3'b110, 3'b000, 16'h0001, "R6 mask A");
        send(3'b000, 3'b111, 16'h7777, "R6 stage both");
        ldac_pulse("R6 load with A masked");
        send(3'b110, 3'b000, 16'h0000, "R6 unmask");
        ldac_pulse("R6 load unmasked");
        send(3'b111, 3'b000, 16'h0001, "R7 reference on");
        send(3'b000, 3'b000, 16'h8888, "R8 stage A");
        send(3'b101, 3'b000, 16'h0000, "R8 partial reset");
        send(3'b001, 3'b000, 16'h0000, "R8 input kept after partial reset");
        send(3'b110, 3'b000, 16'h0003, "R8 mask both");
        send(3'b101, 3'b000, 16'h0001, "R8 full reset");
        send(3'b000, 3'b111, 16'h9999, "R8 stage after full reset");
        ldac_pulse("R8 mask cleared by full reset");

        send(3'b111, 3'b000, 16'h0001, "R9 reference on again");
        send(3'b100, 3'b000, 16'h0021, "R9 power-down A");
        clr_fall_only();
        push("R9 clear zeroes codes, keeps pd and ref");
        clr_release();
        send(3'b001, 3'b111, 16'h0000, "R9 inputs zeroed by clear");

        clr_fall_only();
        send(3'b000, 3'b111, 16'hAAAA, "R10 stage while clear low");
        ldac_pulse("R10 load ignored while clear low");
        clr_release();
        ldac_pulse("R10 load after clear released");

        send(3'b011, 3'b111, 16'h1357, "R11 preset");
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        clr_fall_only();
        @(negedge clk) begin frame_valid = 1'b1; frame_word = {2'b00, 3'b011, 3'b111, 16'hBEEF}; end
        @(negedge clk) frame_valid = 1'b0;
        @(negedge clk) push("R11 aborted frame discarded");
        clr_release();
        send(3'b011, 3'b000, 16'h2468, "R11 next frame applied");

        base = hs_pulses;
        hs_active = 1'b1;
        clr_fall_only();
        clr_release();
        hs_active = 1'b0;
        checks++;
        if (hs_pulses - base != 1) begin
            errors++;
            $display("FAIL R12 hs exit pulses=%0d expected 1", hs_pulses - base);
        end
        push("R12 clear zeroes codes");
        base = hs_pulses;
        clr_fall_only();
        clr_release();
        checks++;
        if (hs_pulses - base != 0) begin
            errors++;
            $display("FAIL R12 hs exit pulses without hs=%0d expected 0", hs_pulses - base);
        end

        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule